// File: doc/BRIEF.md
# Keyed Software Reset Controller

This block holds a bank of per-module reset lines that software drives over a 32-bit register bus. A reset word register carries one bit per line, with 1 meaning the line is held in reset. Writes to this register take effect only when the top byte of the write data carries a fixed key value. A misdirected or corrupted store therefore cannot reset a peripheral.

A second register, the grant mask, holds one bit per line. A line follows software only while its grant bit is set. The intended use is to grant a line first and then set its reset bit. To release it, software clears the reset bit first and then withdraws the grant. Both registers can be read back. A build parameter removes the grant mask; the reset word alone then drives the lines.

Resynchronising the reset lines into other clock domains and ordering them between domains are handled outside this block.

Top module: `swrst_bank`

## Requirements
- R1: After power-on reset, the reset word and the grant mask are both zero, every reset line is low and every read returns zero.
- R2: A write to offset 0x18 whose bits [31:24] equal 0x88 loads bits [23:0] into the reset word. The new value is visible on the lines and on read-back from the next clock edge.
- R3: A write to offset 0x18 whose bits [31:24] differ from 0x88 leaves the reset word and all lines unchanged.
- R4: A write to offset 0xFC loads bits [23:0] into the grant mask whatever the upper byte holds. A read of 0xFC returns the mask in [23:0] and zeros above.
- R5: With the grant mask present, reset line i (bit i of `lineRst`) is high exactly when reset-word bit i and grant bit i are both 1.
- R6: A read of offset 0x18 returns the stored reset word in bits [23:0] and zeros in bits [31:24], even after a keyed write that had ones in those positions.
- R7: Writes to any offset other than 0x18 and 0xFC change no register and no line. Reads of such offsets return zero.
- R8: A reset bit written while its grant bit is clear is stored, not discarded. Its line goes high as soon as the grant is given, and drops as soon as either bit is cleared.
- R9: Read data appears on `busRdata` one clock after the cycle with `busRd` high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data; the top byte is the key for the reset word |
| busRdata | output | 32 | Registered read data |
| lineRst | output | 24 | Per-module reset lines, active high |

## Verification
The bench tries writes to the reset word with wrong keys, including the all-zero byte and a value one away from the key. A design that checks only part of the key byte, or ignores it, would change the lines on those writes. It sets reset bits while their grants are clear and then gives the grants. A design that masks at write time would lose the stored bit, and one that ignores the mask would raise the line too early. It also writes ones into the key byte position and to unused offsets. A controller that stores the key byte would read back nonzero upper bits, and one with loose address decoding would corrupt the registers.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // read source picked by the control for the datapath read mux
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WORD = 2'd1,
    RD_MASK = 2'd2
  } rdSel_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic   ldWord;
    logic   ldMask;
    logic   rdStb;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  KEY      = 8'h88,
  parameter int unsigned WORD_OFS = 'h18,
  parameter int unsigned MASK_OFS = 'hFC,
  parameter bit          HAS_MASK = 1'b1
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        keyByte,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] WordAddr = ADDR_W'(WORD_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  logic hitWord;
  logic hitMask;
  logic keyOk;

  assign hitWord = (busAddr == WordAddr);
  assign keyOk   = (keyByte == KEY);

  generate
    if (HAS_MASK) begin : g_maskDec
      assign hitMask = (busAddr == MaskAddr);
    end else begin : g_noMaskDec
      assign hitMask = 1'b0;
    end
  endgenerate

  always_comb begin
    strb        = '0;
    strb.ldWord = busWr && hitWord && keyOk;
    strb.ldMask = busWr && hitMask;
    strb.rdStb  = busRd;
    if (hitWord)      strb.rdSel = RD_WORD;
    else if (hitMask) strb.rdSel = RD_MASK;
    else              strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/swrst_datapath.sv
module swrst_datapath
  import swrst_pkg::*;
#(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned DATA_W    = 32,
  parameter bit          HAS_MASK  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [NUM_LINES-1:0] wrBits,
  output logic [NUM_LINES-1:0] lineRst,
  output logic [DATA_W-1:0]    rdData
);

  localparam int unsigned PadW = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] wordReg;
  logic [NUM_LINES-1:0] maskVal;
  logic [DATA_W-1:0]    rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordReg <= '0;
    else if (strb.ldWord) wordReg <= wrBits;
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic [NUM_LINES-1:0] maskReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            maskReg <= '0;
        else if (strb.ldMask) maskReg <= wrBits;
      end
      assign maskVal = maskReg;
      assign lineRst = wordReg & maskReg;
    end else begin : g_noMask
      assign maskVal = '0;
      assign lineRst = wordReg;
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      RD_WORD: rdNext = {{PadW{1'b0}}, wordReg};
      RD_MASK: rdNext = {{PadW{1'b0}}, maskVal};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdStb) rdData <= rdNext;
  end

endmodule

// File: rtl/swrst_bank.sv
module swrst_bank
  import swrst_pkg::*;
#(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  KEY       = 8'h88,
  parameter int unsigned WORD_OFS  = 'h18,
  parameter int unsigned MASK_OFS  = 'hFC,
  parameter bit          HAS_MASK  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_LINES-1:0] lineRst
);

  localparam int unsigned DataW  = 32;
  localparam int unsigned KeyLsb = DataW - 8;

  ctrlStrb_t strb;

  swrst_ctrl #(
    .ADDR_W  (ADDR_W),
    .KEY     (KEY),
    .WORD_OFS(WORD_OFS),
    .MASK_OFS(MASK_OFS),
    .HAS_MASK(HAS_MASK)
  ) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .keyByte(busWdata[DataW-1:KeyLsb]),
    .strb   (strb)
  );

  swrst_datapath #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DataW),
    .HAS_MASK (HAS_MASK)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrBits (busWdata[NUM_LINES-1:0]),
    .lineRst(lineRst),
    .rdData (busRdata)
  );

endmodule

// File: rtl/swrst_bank_chk.sv
module swrst_bank_chk #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  KEY       = 8'h88,
  parameter int unsigned WORD_OFS  = 'h18,
  parameter int unsigned MASK_OFS  = 'hFC
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWr,
  input logic                 busRd,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NUM_LINES-1:0] lineRst
);

  localparam logic [ADDR_W-1:0] WordAddr = ADDR_W'(WORD_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  AST_LINES_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (lineRst == '0)); // R1

  AST_KEYED_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == WordAddr && busWdata[31:24] == KEY && busWdata[NUM_LINES-1:0] == '0)
    |=> (lineRst == '0)); // R2

  AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == WordAddr && busWdata[31:24] != KEY) |=> $stable(lineRst)); // R3

  AST_NO_GRANT_NO_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == MaskAddr && busWdata[NUM_LINES-1:0] == '0) |=> (lineRst == '0)); // R5

  AST_WORD_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == WordAddr) |=> (busRdata[31:NUM_LINES] == '0)); // R6

  AST_STRAY_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != WordAddr && busAddr != MaskAddr) |=> $stable(lineRst)); // R7

  AST_READ_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata)); // R9

endmodule

bind swrst_bank swrst_bank_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W),
  .KEY      (KEY),
  .WORD_OFS (WORD_OFS),
  .MASK_OFS (MASK_OFS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busRd   (busRd),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .lineRst (lineRst)
);

// File: tb/test_swrst_bank.sv
`timescale 1ns/1ps
module test_swrst_bank;

  localparam int NL = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] lineRst;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the two registers
  logic [NL-1:0] mWord = '0;
  logic [NL-1:0] mMask = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rdItem_t;
  rdItem_t rdQ[$];
  logic    pendRd = 1'b0;

  always #2.5 clk = ~clk;

  swrst_bank i_swrst_bank (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .lineRst (lineRst)
  );

  function automatic void compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // monitor: a read strobe seen at a rising edge yields data by the next falling edge
  always @(posedge clk) pendRd <= busRd;

  always @(negedge clk) begin
    if (pendRd) begin
      if (rdQ.size() == 0) begin
        compare(busRdata, 32'hDEAD_BEEF, "R9 unexpected read data");
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        compare(busRdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
    if (a == 8'h18 && d[31:24] == 8'h88) mWord = d[NL-1:0];
    if (a == 8'hFC) mMask = d[NL-1:0];
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a == 8'h18) return {8'h00, mWord};
    if (a == 8'hFC) return {8'h00, mMask};
    return 32'h0;
  endfunction

  // driver: issue a read and push the expected word for the monitor
  task automatic rd(input logic [7:0] a, input string tag);
    rdItem_t it;
    it.exp = expRead(a);
    it.tag = tag;
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    rdQ.push_back(it);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic chkLines(input string tag);
    compare({8'h00, lineRst}, {8'h00, mWord & mMask}, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkLines("R1 lines after reset");
    compare(busRdata, 32'h0, "R1 read data after reset");
    rd(8'h18, "R1 word reads zero");
    rd(8'hFC, "R1 mask reads zero");

    // R4 mask write ignores key byte
    wr(8'hFC, 32'h5A00_0F0F);
    rd(8'hFC, "R4 mask readback");
    chkLines("R4 lines unchanged by grant alone");

    // R3 bad keys
    wr(8'h18, 32'h77FF_FFFF);
    chkLines("R3 key 0x77 ignored");
    wr(8'h18, 32'h00FF_FFFF);
    chkLines("R3 key 0x00 ignored");
    wr(8'h18, 32'h89FF_FFFF);
    chkLines("R3 key 0x89 ignored");
    rd(8'h18, "R3 word still zero");

    // R2 + R5 good key, output gated by mask
    wr(8'h18, 32'h8800_0303);
    chkLines("R2 keyed write drives lines");
    chkLines("R5 lines are word and mask");
    rd(8'h18, "R2 word readback");

    // R6 key byte never stored
    wr(8'h18, 32'h88FF_FFFF);
    rd(8'h18, "R6 upper byte reads zero");
    chkLines("R5 full word masked");

    // R8 stored bit waits for grant
    wr(8'h18, 32'h8880_0000);
    chkLines("R8 bit 23 held without grant");
    wr(8'hFC, 32'h0080_0000);
    chkLines("R8 bit 23 asserts on grant");
    wr(8'h18, 32'h8800_0000);
    chkLines("R8 release by clearing word bit");
    wr(8'h18, 32'h8880_0000);
    chkLines("R8 reasserts with grant held");
    wr(8'hFC, 32'h0000_0000);
    chkLines("R8 release by withdrawing grant");
    rd(8'h18, "R8 word bit kept after grant cleared");

    // R7 stray offsets
    wr(8'hFC, 32'h00FF_FFFF);
    wr(8'h1C, 32'h8800_0000);
    chkLines("R7 write to 0x1C no effect");
    wr(8'h14, 32'h8800_0001);
    chkLines("R7 write to 0x14 no effect");
    rd(8'h18, "R7 word intact");
    rd(8'hFC, "R7 mask intact");
    rd(8'h1C, "R7 unused offset reads zero");

    // R9 read data holds without strobe
    rd(8'hFC, "R9 read before hold");
    repeat (3) @(negedge clk);
    compare(busRdata, {8'h00, mMask}, "R9 read data holds");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule